// File: doc/BRIEF.md
# Registered Decimal Add/Subtract Unit

This unit is the decimal-mode adder inside an 8-bit processor datapath. It accepts two packed-BCD operands, a carry input and a subtract select, and returns a decimal-corrected result with a carry bit and an overflow flag. For subtraction, the upstream operand multiplexer presents the subtrahend already inverted bit by bit. The unit adds it with the carry input, where carry 1 means no borrow, and then applies decimal correction.

The outputs are registered. A result and its valid strobe appear on the clock after the enable is sampled high, and the surrounding core stretches its cycle by one clock to wait for them. Whenever the strobe is low, every result bit is held at zero, so the outputs can be ORed onto a shared result bus with the other functional units. The enable is gated upstream: it is raised only for add-with-carry and subtract-with-carry while decimal mode is set.

Top module: `dec_addsub_unit`

## Requirements
- R1: With `sub_i`=0 and valid BCD digits on both operands, `res_q[7:0]` is the two BCD digits of (A + B + `carry_i`) mod 100, with the tens digit in bits 7:4 and the units digit in bits 3:0. `res_q[8]` is 1 exactly when A + B + `carry_i` > 99.
- R2: With `sub_i`=1, `opb_i` carries the bitwise inverse of the BCD subtrahend B. `res_q[7:0]` is then the BCD digits of (A − B − (1 − `carry_i`)) mod 100. `res_q[8]` is 1 when that difference is not negative, which means no borrow.
- R3: `ovf_q` is the XOR of the carry into bit 7 and the carry out of bit 7 of the intermediate sum. The intermediate sum is the high digits A[7:4] + opb[7:4] + c, where c is the decimal carry produced by the low digit, taken before the high digit is corrected.
- R4: `valid_q` is high in the cycle after a cycle in which `en_i` was sampled high, and low in the cycle after a cycle in which it was sampled low.
- R5: While `valid_q` is low, `res_q` is all zeros and `ovf_q` is 0.
- R6: If `en_i` is held high on consecutive cycles, each cycle delivers a fresh result computed from the inputs of the previous cycle, and `valid_q` stays high.
- R7: A synchronous active-high `rst` clears `res_q`, `ovf_q` and `valid_q` on the next clock, even if `en_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Start a decimal operation this cycle |
| sub_i | input | 1 | 1 selects subtraction, 0 selects addition |
| carry_i | input | 1 | Carry in; for subtraction 1 means no borrow |
| opa_i | input | 8 | First BCD operand |
| opb_i | input | 8 | Second BCD operand, inverted bit by bit when subtracting |
| res_q | output | 9 | Bit 8 carry out, bits 7:0 BCD result; zero when idle |
| ovf_q | output | 1 | Overflow flag; zero when idle |
| valid_q | output | 1 | Result strobe, one clock after the enable |

## Verification
Every result, carry, overflow and strobe is due exactly one rising edge after the cycle whose inputs produced it. Reset also takes effect one edge later. The bench drives the inputs on the falling edge and reads the outputs on the next falling edge, half a period after the register updates. At that point it compares them with the expectation it computed for the inputs it drove one period before. It sweeps all 100×100 digit pairs in both directions with both carry values, with the enable held high back to back. Idle gaps and a reset pulse taken while the enable is high are placed between groups, and each of them is checked against zero on that same one-edge schedule.

// File: rtl/dec_addsub_pkg.sv
`timescale 1ns/1ps
package dec_addsub_pkg;
    localparam int NIB_W = 4;
    localparam logic [NIB_W:0]   DEC_LIMIT = 5'd9;
    localparam logic [NIB_W-1:0] DEC_ADJ   = 4'd6;

    typedef struct packed {
        logic [NIB_W-1:0] digit;
        logic             carry;
    } digit_out_t;
endpackage

// File: rtl/dec_digit_slice.sv
`timescale 1ns/1ps
module dec_digit_slice
    import dec_addsub_pkg::*;
(
    input  logic [NIB_W-1:0] a_i,
    input  logic [NIB_W-1:0] b_i,
    input  logic             cin_i,
    input  logic             sub_i,
    output digit_out_t       out_o
);
    logic [NIB_W:0] raw_d;
    logic           over_d;

    always_comb begin
        raw_d  = {1'b0, a_i} + {1'b0, b_i} + {{NIB_W{1'b0}}, cin_i};
        over_d = (raw_d > DEC_LIMIT);
        if (sub_i) begin
            out_o.carry = raw_d[NIB_W];
            out_o.digit = raw_d[NIB_W] ? raw_d[NIB_W-1:0]
                                       : raw_d[NIB_W-1:0] - DEC_ADJ;
        end else begin
            out_o.carry = over_d;
            out_o.digit = over_d ? raw_d[NIB_W-1:0] + DEC_ADJ
                                 : raw_d[NIB_W-1:0];
        end
    end
endmodule

// File: rtl/dec_carry_chain.sv
`timescale 1ns/1ps
module dec_carry_chain
    import dec_addsub_pkg::*;
#(
    parameter int DIGITS = 2,
    localparam int W = DIGITS * NIB_W
)(
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    logic [DIGITS:0] chain_d;
    digit_out_t      slice_d [DIGITS];

    assign chain_d[0] = cin_i;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        dec_digit_slice u_slice (
            .a_i   (a_i[g*NIB_W +: NIB_W]),
            .b_i   (b_i[g*NIB_W +: NIB_W]),
            .cin_i (chain_d[g]),
            .sub_i (sub_i),
            .out_o (slice_d[g])
        );
        assign chain_d[g+1]            = slice_d[g].carry;
        assign sum_o[g*NIB_W +: NIB_W] = slice_d[g].digit;
    end

    // overflow from the top digit's intermediate sum, before its correction
    logic [NIB_W-1:0] low3_d;
    logic [NIB_W:0]   top_d;
    always_comb begin
        low3_d = {1'b0, a_i[W-2 -: NIB_W-1]} + {1'b0, b_i[W-2 -: NIB_W-1]}
               + {{(NIB_W-1){1'b0}}, chain_d[DIGITS-1]};
        top_d  = {1'b0, a_i[W-1 -: NIB_W]} + {1'b0, b_i[W-1 -: NIB_W]}
               + {{NIB_W{1'b0}}, chain_d[DIGITS-1]};
        ovf_o  = low3_d[NIB_W-1] ^ top_d[NIB_W];
    end

    assign cout_o = chain_d[DIGITS];
endmodule

// File: rtl/dec_addsub_unit.sv
`timescale 1ns/1ps
module dec_addsub_unit
    import dec_addsub_pkg::*;
#(
    parameter int DIGITS = 2,
    localparam int W = DIGITS * NIB_W
)(
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic         sub_i,
    input  logic         carry_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    output logic [W:0]   res_q,
    output logic         ovf_q,
    output logic         valid_q
);
    typedef struct packed {
        logic         vld;
        logic         ovf;
        logic [W:0]   res;
    } unit_state_t;

    unit_state_t  nxt_d, cur_q;
    logic [W-1:0] sum_d;
    logic         cout_d, ovf_d;

    dec_carry_chain #(.DIGITS(DIGITS)) u_chain (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .cin_i  (carry_i),
        .sub_i  (sub_i),
        .sum_o  (sum_d),
        .cout_o (cout_d),
        .ovf_o  (ovf_d)
    );

    always_comb begin
        nxt_d     = '0;
        nxt_d.vld = en_i;
        if (en_i) begin
            nxt_d.res = {cout_d, sum_d};
            nxt_d.ovf = ovf_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt_d;
    end

    assign res_q   = cur_q.res;
    assign ovf_q   = cur_q.ovf;
    assign valid_q = cur_q.vld;

    AST_VALID_AFTER_EN: assert property (@(posedge clk) disable iff (rst)
        en_i |=> valid_q);                                        // R4
    AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !valid_q);                                      // R4
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> (res_q == '0 && !ovf_q));                    // R5
    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        (en_i && valid_q) |=> valid_q);                           // R6
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!valid_q && res_q == '0 && !ovf_q));             // R7

    for (genvar g = 0; g < DIGITS; g++) begin : g_chk
        AST_DIGIT_DECIMAL: assert property (@(posedge clk) disable iff (rst)
            valid_q |-> ({1'b0, res_q[g*NIB_W +: NIB_W]} <= DEC_LIMIT)); // R1
    end
endmodule

// File: tb/sim_dec_addsub_unit.sv
`timescale 1ns/1ps
module sim_dec_addsub_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_i = 1'b0, sub_i = 1'b0, carry_i = 1'b0;
    logic [7:0] opa_i = '0, opb_i = '0;
    logic [8:0] res_q;
    logic       ovf_q, valid_q;

    int  n_chk = 0, n_fail = 0;
    bit  done = 0;

    always #2 clk = ~clk;

    dec_addsub_unit u0 (
        .clk(clk), .rst(rst), .en_i(en_i), .sub_i(sub_i), .carry_i(carry_i),
        .opa_i(opa_i), .opb_i(opb_i), .res_q(res_q), .ovf_q(ovf_q),
        .valid_q(valid_q)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    // overflow from the requirement: carries into/out of bit 7 of the high-digit sum
    function automatic int exp_ovf(input int a, input int bop, input int ci, input int s);
        int al = a % 10, ah = a / 10;
        int bl = bop & 15, bh = (bop >> 4) & 15;
        int lo = al + bl + ci;
        int c  = s ? (lo >= 16) : (lo > 9);
        int cin7  = (((ah & 7) + (bh & 7) + c) >> 3) & 1;
        int cout7 = ((ah + bh + c) >> 4) & 1;
        return cin7 ^ cout7;
    endfunction

    // expectation for the operation driven one period earlier
    bit pend = 0;
    int e_res, e_ovf;
    string e_tag;

    task automatic check_pending();
        if (pend) begin
            chk({e_tag, " valid R4 R6"}, int'(valid_q), 1);
            chk({e_tag, " result"}, int'(res_q), e_res);
            chk("R3 overflow", int'(ovf_q), e_ovf);
        end else begin
            chk("R5 idle valid", int'(valid_q), 0);
            chk("R5 idle result", int'(res_q), 0);
            chk("R5 idle ovf", int'(ovf_q), 0);
        end
    endtask

    task automatic issue(input int a, input int b, input int ci, input int s);
        int v, cy;
        @(negedge clk);
        check_pending();
        en_i = 1'b1; sub_i = s[0]; carry_i = ci[0];
        opa_i = bcd(a);
        opb_i = s ? ~bcd(b) : bcd(b);
        if (s == 0) begin
            v = a + b + ci; cy = (v > 99); v = v % 100; e_tag = "R1 add";
        end else begin
            v = a - b - (1 - ci); cy = (v >= 0); if (v < 0) v += 100; e_tag = "R2 sub";
        end
        e_res = (cy << 8) | int'(bcd(v));
        e_ovf = exp_ovf(a, int'(opb_i), ci, s);
        pend  = 1;
    endtask

    task automatic idle();
        @(negedge clk);
        check_pending();
        en_i = 1'b0; opa_i = 8'h99; opb_i = 8'h99; carry_i = 1'b1;
        pend = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R7 reset valid", int'(valid_q), 0);
        chk("R7 reset result", int'(res_q), 0);
        chk("R7 reset ovf", int'(ovf_q), 0);
        rst = 1'b0;
        for (int s = 0; s < 2; s++)
            for (int ci = 0; ci < 2; ci++)
                for (int a = 0; a < 100; a++) begin
                    for (int b = 0; b < 100; b++) issue(a, b, ci, s);
                    if (a % 9 == 4) begin idle(); idle(); end
                end
        idle();
        idle();
        // reset taken while enable is high
        issue(99, 99, 1, 0);
        @(negedge clk);
        rst = 1'b1;
        en_i = 1'b1;
        @(negedge clk);
        chk("R7 reset during enable valid", int'(valid_q), 0);
        chk("R7 reset during enable result", int'(res_q), 0);
        chk("R7 reset during enable ovf", int'(ovf_q), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R4 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule